// File: doc/BRIEF.md
# Branch Target Buffer with One-Bit Direction State

This block sits beside instruction fetch and guesses where fetch goes next. Each cycle the fetch unit presents the PC it is fetching. One clock edge later the block returns the PC to fetch next and a flag that says whether a taken branch was predicted. The block is a direct-mapped table. Each slot holds a valid bit, an address tag, a target address and a single direction bit. The guess depends only on the fetch PC and on what that branch did before.

The backend reports each resolved branch on a feedback port. A report carries the branch PC, whether the branch was taken, its real target, and whether the earlier guess was wrong. The table changes only on wrong guesses. A taken branch that was guessed wrong claims its slot, and its direction bit is set. A not-taken branch that was guessed taken clears the direction bit in its slot. This means one bit covers both "is this a branch" and "which way". A loop-closing branch therefore costs one miss on entry and one miss on exit.

Top module: `branch_target_predictor`

## Requirements
- R1: After reset every slot is invalid. Until feedback arrives, every lookup returns pred_taken = 0 and next_pc = fetch_pc + 4.
- R2: A lookup is accepted on every clock edge with no stall. The result for the fetch_pc sampled at edge k is on next_pc and pred_taken after edge k, and stays there until edge k+1.
- R3: If no valid slot holds the fetch PC, the result is pred_taken = 0 and next_pc = fetch_pc + 4.
- R4: If a valid slot holds the fetch PC and its direction bit is 1, the result is pred_taken = 1 and next_pc is the stored target.
- R5: If a valid slot holds the fetch PC and its direction bit is 0, the result is pred_taken = 0 and next_pc = fetch_pc + 4.
- R6: Feedback with fb_valid = 1, fb_mispredict = 1 and fb_taken = 1 writes the branch PC tag and fb_target into the slot and sets its direction bit to 1. Any previous occupant of that slot is replaced. The change is seen by lookups sampled at later edges.
- R7: Feedback with fb_valid = 1, fb_mispredict = 1 and fb_taken = 0 clears the direction bit of the addressed slot. The tag and target are left as they were.
- R8: Feedback with fb_mispredict = 0 leaves the table unchanged, whatever fb_taken and fb_target are.
- R9: If a lookup and an update address the same slot at the same edge, the lookup returns the slot's contents from before the update.
- R10: The slot index is fetch PC bits [IDX_W+1:2]. All other PC bits, including bits [1:0], form the tag. Two PCs that share an index but differ in tag do not hit on each other's slot.
- R11: When fb_valid = 0, the other feedback inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC being fetched this cycle |
| next_pc | output | PC_W | Predicted next fetch PC for the previous edge's fetch_pc |
| pred_taken | output | 1 | High when a taken branch is predicted |
| fb_valid | input | 1 | Feedback report present |
| fb_pc | input | PC_W | PC of the resolved branch |
| fb_taken | input | 1 | Actual direction of the resolved branch |
| fb_target | input | PC_W | Actual target of the resolved branch |
| fb_mispredict | input | 1 | The earlier prediction for this branch was wrong |

## Verification
Every slot's contents reach the ports through a single lookup, one edge later. A bad tag, target, valid bit or direction bit therefore shows up on the first lookup of that PC after the faulty update. It appears as a wrong pred_taken or as next_pc switching between the target and fetch_pc + 4. The tests first set each slot state through feedback and then read it back with lookups. The pairs of aliasing PCs expose index or tag slicing errors. The same-edge test exposes write-before-read ordering in the storage.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE  = 2'd0,
    UPD_ALLOC = 2'd1,
    UPD_CLEAR = 2'd2
  } upd_kind_e;
endpackage

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
  import btb_pkg::*;
(
  input  logic      fb_valid,
  input  logic      fb_taken,
  input  logic      fb_mispredict,
  output upd_kind_e kind
);
  always_comb begin
    kind = UPD_NONE;
    if (fb_valid && fb_mispredict) begin
      if (fb_taken) kind = UPD_ALLOC;
      else          kind = UPD_CLEAR;
    end
  end
endmodule

// File: rtl/btb_ram.sv
module btb_ram #(
  parameter int W     = 56,
  parameter int ADR_W = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ADR_W-1:0] waddr,
  input  logic [W-1:0]     wdata,
  input  logic [ADR_W-1:0] raddr,
  output logic [W-1:0]     rdata
);
  localparam int DEPTH = 1 << ADR_W;

  logic [W-1:0] mem [DEPTH];

  // read-first: the read register takes the word held before this edge's write
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/btb_flags.sv
module btb_flags
  import btb_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  upd_kind_e        kind,
  input  logic [IDX_W-1:0] widx,
  input  logic [IDX_W-1:0] ridx,
  output logic             valid_q,
  output logic             dir_q
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0] valid_r;
  logic [N-1:0] dir_r;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_r[g] <= 1'b0;
          dir_r[g]   <= 1'b0;
        end else if (widx == IDX_W'(g)) begin
          if (kind == UPD_ALLOC) begin
            valid_r[g] <= 1'b1;
            dir_r[g]   <= 1'b1;
          end else if (kind == UPD_CLEAR) begin
            dir_r[g]   <= 1'b0;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      valid_q <= valid_r[ridx];
      dir_q   <= dir_r[ridx];
    end
  end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup #(
  parameter int PC_W  = 32,
  parameter int TAG_W = 26
) (
  input  logic [PC_W-1:0]  pc_q,
  input  logic [TAG_W-1:0] tag_q,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PC_W-1:0]  rd_target,
  input  logic             valid_q,
  input  logic             dir_q,
  output logic [PC_W-1:0]  next_pc,
  output logic             pred_taken
);
  logic hit;

  always_comb begin
    hit        = valid_q && (rd_tag == tag_q);
    pred_taken = hit && dir_q;
    next_pc    = pred_taken ? rd_target : pc_q + PC_W'(4);
  end
endmodule

// File: rtl/branch_target_predictor.sv
module branch_target_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            pred_taken,
  input  logic            fb_valid,
  input  logic [PC_W-1:0] fb_pc,
  input  logic            fb_taken,
  input  logic [PC_W-1:0] fb_target,
  input  logic            fb_mispredict
);
  localparam int TAG_W   = PC_W - IDX_W;
  localparam int ENTRY_W = TAG_W + PC_W;

  function automatic logic [IDX_W-1:0] idx_of(input logic [PC_W-1:0] pc);
    return pc[IDX_W+1:2];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return {pc[PC_W-1:IDX_W+2], pc[1:0]};
  endfunction

  upd_kind_e          kind;
  logic [ENTRY_W-1:0] rd_entry;
  logic               valid_q;
  logic               dir_q;
  logic [PC_W-1:0]    pc_q;

  btb_update_ctl u_ctl (
    .fb_valid      (fb_valid),
    .fb_taken      (fb_taken),
    .fb_mispredict (fb_mispredict),
    .kind          (kind)
  );

  btb_ram #(.W(ENTRY_W), .ADR_W(IDX_W)) u_ram (
    .clk   (clk),
    .we    (kind == UPD_ALLOC),
    .waddr (idx_of(fb_pc)),
    .wdata ({tag_of(fb_pc), fb_target}),
    .raddr (idx_of(fetch_pc)),
    .rdata (rd_entry)
  );

  btb_flags #(.IDX_W(IDX_W)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .kind    (kind),
    .widx    (idx_of(fb_pc)),
    .ridx    (idx_of(fetch_pc)),
    .valid_q (valid_q),
    .dir_q   (dir_q)
  );

  always_ff @(posedge clk) pc_q <= fetch_pc;

  btb_lookup #(.PC_W(PC_W), .TAG_W(TAG_W)) u_look (
    .pc_q       (pc_q),
    .tag_q      (tag_of(pc_q)),
    .rd_tag     (rd_entry[ENTRY_W-1:PC_W]),
    .rd_target  (rd_entry[PC_W-1:0]),
    .valid_q    (valid_q),
    .dir_q      (dir_q),
    .next_pc    (next_pc),
    .pred_taken (pred_taken)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] next_pc,
  input logic            pred_taken,
  input logic            fb_valid,
  input logic [PC_W-1:0] fb_pc,
  input logic            fb_taken,
  input logic [PC_W-1:0] fb_target,
  input logic            fb_mispredict
);
  AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pred_taken); // R1

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> next_pc == $past(fetch_pc) + PC_W'(4)); // R3

  AST_ALLOC_HITS: assert property (@(posedge clk) disable iff (rst)
    ($past(fb_valid && fb_mispredict && fb_taken, 2) && $past(fetch_pc) == $past(fb_pc, 2))
    |-> (pred_taken && next_pc == $past(fb_target, 2))); // R6

  AST_CLEAR_NOT_TAKEN: assert property (@(posedge clk) disable iff (rst)
    ($past(fb_valid && fb_mispredict && !fb_taken, 2) && $past(fetch_pc) == $past(fb_pc, 2))
    |-> !pred_taken); // R7

  AST_NEXT_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(pred_taken)); // R2
endmodule

bind branch_target_predictor btb_checker #(.PC_W(PC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fetch_pc      (fetch_pc),
  .next_pc       (next_pc),
  .pred_taken    (pred_taken),
  .fb_valid      (fb_valid),
  .fb_pc         (fb_pc),
  .fb_taken      (fb_taken),
  .fb_target     (fb_target),
  .fb_mispredict (fb_mispredict)
);

// File: tb/sim_branch_target_predictor.sv
module sim_branch_target_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int IDX_W = 6;
  localparam logic [31:0] STRIDE = 32'(1 << (IDX_W + 2));

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [PC_W-1:0] fetch_pc = '0;
  logic [PC_W-1:0] next_pc;
  logic            pred_taken;
  logic            fb_valid = 1'b0;
  logic [PC_W-1:0] fb_pc = '0;
  logic            fb_taken = 1'b0;
  logic [PC_W-1:0] fb_target = '0;
  logic            fb_mispredict = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_taken(pred_taken), .fb_valid(fb_valid), .fb_pc(fb_pc),
    .fb_taken(fb_taken), .fb_target(fb_target), .fb_mispredict(fb_mispredict)
  );

  task automatic expect_out(input string req, input logic exp_t, input logic [PC_W-1:0] exp_n);
    checks++;
    if (pred_taken !== exp_t || next_pc !== exp_n) begin
      errors++;
      $display("FAIL %s: taken=%0b next=%h expected taken=%0b next=%h",
               req, pred_taken, next_pc, exp_t, exp_n);
    end
  endtask

  // present one lookup, then sample after the edge that registers it
  task automatic lookup(input logic [PC_W-1:0] pc, input string req,
                        input logic exp_t, input logic [PC_W-1:0] exp_n);
    @(negedge clk);
    fetch_pc = pc;
    fb_valid = 1'b0;
    @(posedge clk); #1;
    expect_out(req, exp_t, exp_n);
  endtask

  task automatic feedback(input logic v, input logic [PC_W-1:0] pc, input logic tk,
                          input logic [PC_W-1:0] tgt, input logic mis);
    @(negedge clk);
    fb_valid = v; fb_pc = pc; fb_taken = tk; fb_target = tgt; fb_mispredict = mis;
    @(negedge clk);
    fb_valid = 1'b0;
  endtask

  task automatic t_reset;
    lookup(32'h0000_0100, "R1", 1'b0, 32'h0000_0104);
    lookup(32'h0000_1000, "R1", 1'b0, 32'h0000_1004);
  endtask

  task automatic t_miss;
    lookup(32'h0000_2000, "R3", 1'b0, 32'h0000_2004);
    lookup(32'hFFFF_FFFC, "R3", 1'b0, 32'h0000_0000);
  endtask

  task automatic t_alloc;
    feedback(1'b1, 32'h0000_1000, 1'b1, 32'h0000_0F00, 1'b1);
    lookup(32'h0000_1000, "R6 R4", 1'b1, 32'h0000_0F00);
    // back-to-back lookups, one per edge
    lookup(32'h0000_2000, "R2", 1'b0, 32'h0000_2004);
    lookup(32'h0000_1000, "R2", 1'b1, 32'h0000_0F00);
    lookup(32'h0000_1004, "R10", 1'b0, 32'h0000_1008);
  endtask

  task automatic t_correct;
    feedback(1'b1, 32'h0000_1000, 1'b1, 32'h0000_5554, 1'b0);
    lookup(32'h0000_1000, "R8", 1'b1, 32'h0000_0F00);
    feedback(1'b1, 32'h0000_1000, 1'b0, 32'h0000_0000, 1'b0);
    lookup(32'h0000_1000, "R8", 1'b1, 32'h0000_0F00);
  endtask

  task automatic t_ignored;
    feedback(1'b0, 32'h0000_2000, 1'b1, 32'h0000_7000, 1'b1);
    lookup(32'h0000_2000, "R11", 1'b0, 32'h0000_2004);
    feedback(1'b0, 32'h0000_1000, 1'b0, 32'h0000_0000, 1'b1);
    lookup(32'h0000_1000, "R11", 1'b1, 32'h0000_0F00);
  endtask

  task automatic t_clear;
    feedback(1'b1, 32'h0000_1000, 1'b0, 32'h0000_1004, 1'b1);
    lookup(32'h0000_1000, "R7 R5", 1'b0, 32'h0000_1004);
    feedback(1'b1, 32'h0000_1000, 1'b1, 32'h0000_0F00, 1'b1);
    lookup(32'h0000_1000, "R6", 1'b1, 32'h0000_0F00);
  endtask

  task automatic t_same_edge;
    @(negedge clk);
    fetch_pc = 32'h0000_3000;
    fb_valid = 1'b1; fb_pc = 32'h0000_3000; fb_taken = 1'b1;
    fb_target = 32'h0000_0400; fb_mispredict = 1'b1;
    @(posedge clk); #1;
    expect_out("R9", 1'b0, 32'h0000_3004);
    @(negedge clk);
    fb_valid = 1'b0;
    @(posedge clk); #1;
    expect_out("R9", 1'b1, 32'h0000_0400);
  endtask

  task automatic t_alias;
    lookup(32'h0000_1000 + STRIDE, "R10", 1'b0, 32'h0000_1004 + STRIDE);
    feedback(1'b1, 32'h0000_1000 + STRIDE, 1'b1, 32'h0000_0800, 1'b1);
    lookup(32'h0000_1000 + STRIDE, "R10", 1'b1, 32'h0000_0800);
    lookup(32'h0000_1000, "R10", 1'b0, 32'h0000_1004);
    lookup(32'h0000_1002 + STRIDE, "R10", 1'b0, 32'h0000_1006 + STRIDE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_miss();
    t_alloc();
    t_correct();
    t_ignored();
    t_clear();
    t_same_edge();
    t_alias();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule